// File: doc/BRIEF.md
# Processor Register File and Stack Pointer Unit

This block keeps the architectural state of a small 8-bit processor with separate program and data memories: an accumulator, an index register, a 16-bit program counter, an 8-bit stack pointer and an 8-bit flags register. Decode logic and the ALU sit outside. They drive write strobes with data, a program-counter increment, flag results and stack requests. The unit returns the register contents, the address and strobes for one stack access into a 256-byte data RAM, and a bank-select bit taken from the flags. That bit chooses one of two 256-byte register banks.

Stack handling is a four-state machine whose state register records the stack action of the previous cycle. `ST_IDLE` means no access. `ST_PUSH` drives a write strobe with the old pointer as the address. `ST_POP` drives a read strobe with the decremented pointer as the address. `ST_FAULT` raises an error strobe. From any state the next state is chosen by that cycle's requests:
- push alone goes to `ST_PUSH`;
- pop alone goes to `ST_POP`;
- both together go to `ST_FAULT`;
- neither, or a direct pointer write, goes to `ST_IDLE`.

Each stack strobe therefore appears one clock after its request, and the pointer has already moved by then. A push stores at the current pointer and then increments it. A pop decrements the pointer first and then reads at the new value. The flags can also be read through a small register-read port at address F7h, in either bank.

Top module: `cpu_reg_stack_unit`

## Requirements
- R1: After reset the accumulator, index, program counter and stack pointer read 0, and the stack write, read and error strobes are low.
- R2: After reset the flags read 02h: bit 1, the zero flag, is set and every other flag bit is clear.
- R3: A write strobe on the accumulator, index or program counter loads its data at the next clock edge. A program-counter load takes priority over an increment. An increment from FFFFh gives 0000h.
- R4: A push request alone produces, one clock later, a write strobe with the pre-push stack pointer as the address and the request's data on the write-data output. The pointer increments at that same edge, and FFh becomes 00h.
- R5: A pop request alone produces, one clock later, a read strobe whose address is the pointer minus one. The pointer takes that decremented value at that same edge, and 00h becomes FFh.
- R6: A push and a pop requested in the same cycle leave the stack pointer unchanged. One clock later the error strobe is high and the write and read strobes are low. At most one of the three strobes is ever high.
- R7: A direct stack-pointer write takes priority over push and pop requests in the same cycle. It loads its data, and no stack strobe follows.
- R8: The bank-select output equals flags bit 4: 1 selects register bank 1 and 0 selects bank 0.
- R9: The register-read port returns the flags, with its hit output high, when the address is F7h, whatever the bank. Any other address returns 0 with hit low.
- R10: A flag write strobe loads the ALU flag value at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_we | input | 1 | Accumulator write strobe |
| acc_wdata | input | 8 | Accumulator write data |
| idx_we | input | 1 | Index register write strobe |
| idx_wdata | input | 8 | Index register write data |
| pc_we | input | 1 | Program counter load strobe |
| pc_wdata | input | 16 | Program counter load value |
| pc_inc | input | 1 | Program counter increment |
| sp_we | input | 1 | Direct stack pointer write strobe |
| sp_wdata | input | 8 | Stack pointer write data |
| flag_we | input | 1 | Flag update strobe from the ALU |
| flag_wdata | input | 8 | New flag value |
| push_req | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop request |
| rd_addr | input | 8 | Register-read address |
| acc_q | output | 8 | Accumulator |
| idx_q | output | 8 | Index register |
| pc_q | output | 16 | Program counter |
| sp_q | output | 8 | Stack pointer |
| flags_q | output | 8 | Flags register |
| bank_sel | output | 1 | Register bank select |
| rd_hit | output | 1 | Read address matched the flags |
| rd_data | output | 8 | Register-read data |
| stk_addr | output | 8 | Stack RAM address |
| stk_wdata | output | 8 | Stack RAM write data |
| stk_we | output | 1 | Stack RAM write strobe |
| stk_re | output | 1 | Stack RAM read strobe |
| stk_err | output | 1 | Conflicting stack request strobe |

## Verification
Directed sequences are run first:
- a push at pointer FFh and a pop at pointer 00h confirm the wrap in both directions;
- a lone push, a lone pop and a push with a pop in the same cycle separate the `ST_PUSH`, `ST_POP` and `ST_FAULT` paths;
- a pointer write issued together with a push shows that the write wins.

A seeded random run then mixes pushes, pops, conflicts, direct pointer writes, register loads and flag updates with bit 4 toggling. Read addresses in that run alternate between F7h and other values. These patterns separate a post-increment push from a pre-increment push, and a pre-decrement pop from a post-decrement pop. They also separate bank-independent flag reads from reads tied to one bank.

// File: rtl/cru_pkg.sv
package cru_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PUSH  = 2'd1,
        ST_POP   = 2'd2,
        ST_FAULT = 2'd3
    } stk_state_t;

    localparam int          FLAG_ZERO_BIT = 1;
    localparam int          FLAG_BANK_BIT = 4;
    localparam logic [7:0]  FLAG_RESET    = 8'h02;
    localparam logic [7:0]  FLAG_RD_ADDR  = 8'hF7;
endpackage

// File: rtl/cru_stack_ctl.sv
module cru_stack_ctl
    import cru_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [DW-1:0] push_data,
    input  logic          sp_we,
    input  logic [AW-1:0] sp_wdata,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] stk_addr,
    output logic [DW-1:0] stk_wdata,
    output logic          stk_we,
    output logic          stk_re,
    output logic          stk_err
);
    stk_state_t state_q, state_d;

    // next-state selection from this cycle's requests
    always_comb begin
        state_d = ST_IDLE;
        if (!sp_we) begin
            unique case ({push_req, pop_req})
                2'b10:   state_d = ST_PUSH;
                2'b01:   state_d = ST_POP;
                2'b11:   state_d = ST_FAULT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pointer and address datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q      <= '0;
            stk_addr  <= '0;
            stk_wdata <= '0;
        end else if (sp_we) begin
            sp_q <= sp_wdata;
        end else begin
            unique case (state_d)
                ST_PUSH: begin
                    stk_addr  <= sp_q;
                    stk_wdata <= push_data;
                    sp_q      <= sp_q + AW'(1);
                end
                ST_POP: begin
                    stk_addr <= sp_q - AW'(1);
                    sp_q     <= sp_q - AW'(1);
                end
                default: ;
            endcase
        end
    end

    // output decode from the state register
    always_comb begin
        stk_we  = 1'b0;
        stk_re  = 1'b0;
        stk_err = 1'b0;
        unique case (state_q)
            ST_PUSH:  stk_we  = 1'b1;
            ST_POP:   stk_re  = 1'b1;
            ST_FAULT: stk_err = 1'b1;
            default:  ;
        endcase
    end

    p_push_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !sp_we) |=> (stk_we && sp_q == AW'($past(sp_q) + AW'(1)) && stk_addr == $past(sp_q)));
    p_pop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !sp_we) |=> (stk_re && sp_q == AW'($past(sp_q) - AW'(1)) && stk_addr == sp_q));
    p_conflict_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !sp_we) |=> (stk_err && $stable(sp_q)));
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_we, stk_re, stk_err}));
    p_spwe_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |=> (!stk_we && !stk_re && !stk_err && sp_q == $past(sp_wdata)));
endmodule

// File: rtl/cru_arch_regs.sv
module cru_arch_regs
    import cru_pkg::*;
#(
    parameter int DW  = 8,
    parameter int PCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_we,
    input  logic [DW-1:0]  acc_wdata,
    input  logic           idx_we,
    input  logic [DW-1:0]  idx_wdata,
    input  logic           pc_we,
    input  logic [PCW-1:0] pc_wdata,
    input  logic           pc_inc,
    input  logic           flag_we,
    input  logic [DW-1:0]  flag_wdata,
    input  logic [7:0]     rd_addr,
    output logic [DW-1:0]  acc_q,
    output logic [DW-1:0]  idx_q,
    output logic [PCW-1:0] pc_q,
    output logic [DW-1:0]  flags_q,
    output logic           rd_hit,
    output logic [DW-1:0]  rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            idx_q   <= '0;
            pc_q    <= '0;
            flags_q <= DW'(FLAG_RESET);
        end else begin
            if (acc_we)  acc_q   <= acc_wdata;
            if (idx_we)  idx_q   <= idx_wdata;
            if (flag_we) flags_q <= flag_wdata;
            if (pc_we)       pc_q <= pc_wdata;
            else if (pc_inc) pc_q <= pc_q + PCW'(1);
        end
    end

    // flags visible at a fixed address, independent of the bank bit
    always_comb begin
        rd_hit  = (rd_addr == FLAG_RD_ADDR);
        rd_data = rd_hit ? flags_q : '0;
    end

    p_flag_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags_q == DW'(FLAG_RESET)));
    p_pc_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !pc_we) |=> (pc_q == PCW'($past(pc_q) + PCW'(1))));
    p_pc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> (pc_q == $past(pc_wdata)));
    p_flag_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags_q == $past(flag_wdata)));
endmodule

// File: rtl/cpu_reg_stack_unit.sv
module cpu_reg_stack_unit
    import cru_pkg::*;
#(
    parameter int DW  = 8,
    parameter int PCW = 16,
    parameter int AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_we,
    input  logic [DW-1:0]  acc_wdata,
    input  logic           idx_we,
    input  logic [DW-1:0]  idx_wdata,
    input  logic           pc_we,
    input  logic [PCW-1:0] pc_wdata,
    input  logic           pc_inc,
    input  logic           sp_we,
    input  logic [AW-1:0]  sp_wdata,
    input  logic           flag_we,
    input  logic [DW-1:0]  flag_wdata,
    input  logic           push_req,
    input  logic [DW-1:0]  push_data,
    input  logic           pop_req,
    input  logic [7:0]     rd_addr,
    output logic [DW-1:0]  acc_q,
    output logic [DW-1:0]  idx_q,
    output logic [PCW-1:0] pc_q,
    output logic [AW-1:0]  sp_q,
    output logic [DW-1:0]  flags_q,
    output logic           bank_sel,
    output logic           rd_hit,
    output logic [DW-1:0]  rd_data,
    output logic [AW-1:0]  stk_addr,
    output logic [DW-1:0]  stk_wdata,
    output logic           stk_we,
    output logic           stk_re,
    output logic           stk_err
);
    cru_arch_regs #(.DW(DW), .PCW(PCW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_we(acc_we), .acc_wdata(acc_wdata),
        .idx_we(idx_we), .idx_wdata(idx_wdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_inc(pc_inc),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .rd_addr(rd_addr),
        .acc_q(acc_q), .idx_q(idx_q), .pc_q(pc_q), .flags_q(flags_q),
        .rd_hit(rd_hit), .rd_data(rd_data)
    );

    cru_stack_ctl #(.AW(AW), .DW(DW)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
        .sp_we(sp_we), .sp_wdata(sp_wdata),
        .sp_q(sp_q), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .stk_we(stk_we), .stk_re(stk_re), .stk_err(stk_err)
    );

    assign bank_sel = flags_q[FLAG_BANK_BIT];

    p_bank_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (bank_sel == $past(flag_wdata[FLAG_BANK_BIT])));
endmodule

// File: tb/cpu_reg_stack_unit_tb.sv
`timescale 1ns/1ps
module cpu_reg_stack_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic acc_we, idx_we, pc_we, pc_inc, sp_we, flag_we, push_req, pop_req;
    logic [7:0] acc_wdata, idx_wdata, sp_wdata, flag_wdata, push_data, rd_addr;
    logic [15:0] pc_wdata;
    logic [7:0] acc_q, idx_q, sp_q, flags_q, rd_data, stk_addr, stk_wdata;
    logic [15:0] pc_q;
    logic bank_sel, rd_hit, stk_we, stk_re, stk_err;

    cpu_reg_stack_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_inc(pc_inc),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req), .rd_addr(rd_addr),
        .acc_q(acc_q), .idx_q(idx_q), .pc_q(pc_q), .sp_q(sp_q), .flags_q(flags_q),
        .bank_sel(bank_sel), .rd_hit(rd_hit), .rd_data(rd_data),
        .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .stk_we(stk_we), .stk_re(stk_re), .stk_err(stk_err)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [7:0]  e_a, e_x, e_sp, e_f, e_addr, e_wd;
    logic [15:0] e_pc;
    logic        e_we, e_re, e_err;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(logic [7:0] addr, logic [7:0] f);
        return (addr == 8'hF7) ? f : 8'h00;
    endfunction

    task automatic idle_inputs();
        acc_we = 0; idx_we = 0; pc_we = 0; pc_inc = 0; sp_we = 0; flag_we = 0;
        push_req = 0; pop_req = 0;
        acc_wdata = 0; idx_wdata = 0; pc_wdata = 0; sp_wdata = 0; flag_wdata = 0;
        push_data = 0; rd_addr = 0;
    endtask

    // apply the inputs already driven for one clock, update the model, then check
    task automatic step();
        e_we = 0; e_re = 0; e_err = 0;
        if (sp_we) e_sp = sp_wdata;                       // R7
        else if (push_req && pop_req) e_err = 1;          // R6
        else if (push_req) begin                          // R4
            e_we = 1; e_addr = e_sp; e_wd = push_data; e_sp = e_sp + 8'd1;
        end else if (pop_req) begin                       // R5
            e_re = 1; e_sp = e_sp - 8'd1; e_addr = e_sp;
        end
        if (acc_we) e_a = acc_wdata;
        if (idx_we) e_x = idx_wdata;
        if (flag_we) e_f = flag_wdata;
        if (pc_we) e_pc = pc_wdata;
        else if (pc_inc) e_pc = e_pc + 16'd1;
        @(posedge clk);
        @(negedge clk);
        chk("R3 acc", {8'h0, acc_q}, {8'h0, e_a});
        chk("R3 idx", {8'h0, idx_q}, {8'h0, e_x});
        chk("R3 pc", pc_q, e_pc);
        chk("R4/R5 sp", {8'h0, sp_q}, {8'h0, e_sp});
        chk("R4 stk_we", {15'h0, stk_we}, {15'h0, e_we});
        chk("R5 stk_re", {15'h0, stk_re}, {15'h0, e_re});
        chk("R6 stk_err", {15'h0, stk_err}, {15'h0, e_err});
        if (e_we || e_re) chk("R4/R5 stk_addr", {8'h0, stk_addr}, {8'h0, e_addr});
        if (e_we) chk("R4 stk_wdata", {8'h0, stk_wdata}, {8'h0, e_wd});
        chk("R10 flags", {8'h0, flags_q}, {8'h0, e_f});
        chk("R8 bank_sel", {15'h0, bank_sel}, {15'h0, e_f[4]});
        chk("R9 rd_hit", {15'h0, rd_hit}, {15'h0, (rd_addr == 8'hF7)});
        chk("R9 rd_data", {8'h0, rd_data}, {8'h0, exp_rd(rd_addr, e_f)});
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        idle_inputs();
        e_a = 0; e_x = 0; e_pc = 0; e_sp = 0; e_f = 8'h02; e_addr = 0; e_wd = 0;
        repeat (3) @(negedge clk);
        // R1 / R2 reset state
        chk("R1 acc reset", {8'h0, acc_q}, 16'h0);
        chk("R1 idx reset", {8'h0, idx_q}, 16'h0);
        chk("R1 pc reset", pc_q, 16'h0);
        chk("R1 sp reset", {8'h0, sp_q}, 16'h0);
        chk("R1 strobes reset", {13'h0, stk_we, stk_re, stk_err}, 16'h0);
        chk("R2 flags reset", {8'h0, flags_q}, 16'h0002);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 flags after release", {8'h0, flags_q}, 16'h0002);

        // R9 flag read at F7h and miss elsewhere, bank 0
        rd_addr = 8'hF7; step();
        rd_addr = 8'hF6; step();
        // R8 bank 1 then read again
        flag_we = 1; flag_wdata = 8'h13; rd_addr = 8'hF7; step();
        idle_inputs(); rd_addr = 8'hF7; step();
        // R4 push at pointer FFh wraps to 00h
        sp_we = 1; sp_wdata = 8'hFF; step(); idle_inputs();
        push_req = 1; push_data = 8'hA5; step(); idle_inputs();
        // R5 pop at pointer 00h wraps to FFh
        pop_req = 1; step(); idle_inputs();
        // R6 conflicting requests
        push_req = 1; pop_req = 1; push_data = 8'h3C; step(); idle_inputs();
        // R7 direct write with a push
        sp_we = 1; sp_wdata = 8'h40; push_req = 1; push_data = 8'h77; step(); idle_inputs();
        // R3 load priority and increment wrap
        pc_we = 1; pc_wdata = 16'hFFFF; pc_inc = 1; step(); idle_inputs();
        pc_inc = 1; step(); idle_inputs();
        acc_we = 1; acc_wdata = 8'h5A; idx_we = 1; idx_wdata = 8'hC3; step(); idle_inputs();

        // seeded random mix
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            push_req = (r < 35) || (r >= 90 && r < 95);
            pop_req  = (r >= 35 && r < 70) || (r >= 90 && r < 95);
            sp_we    = ($urandom_range(0, 19) == 0);
            sp_wdata = 8'($urandom);
            push_data = 8'($urandom);
            acc_we = $urandom_range(0, 3) == 0; acc_wdata = 8'($urandom);
            idx_we = $urandom_range(0, 3) == 0; idx_wdata = 8'($urandom);
            pc_we  = $urandom_range(0, 9) == 0; pc_wdata = 16'($urandom);
            pc_inc = $urandom_range(0, 1) == 1;
            flag_we = $urandom_range(0, 4) == 0; flag_wdata = 8'($urandom);
            rd_addr = ($urandom_range(0, 1) == 1) ? 8'hF7 : 8'($urandom);
            step();
        end
        idle_inputs();
        step();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule